// File: doc/BRIEF.md
# Multi-Tap Window Shift Queue

This block is a fixed-depth first-in first-out store for image windows. Each entry is a whole window of several pixel words, not a single word. A window arrives on one wide, flat input bus and is split into its stored form inside the block. A push clock edge moves every stored window one place from the head toward the tail. The incoming window takes the head, and the window that was at the tail drops out.

A set of interior positions is chosen when the block is built, and the windows held at those positions are driven out all the time on one wide, flat output bus. A neighbourhood processor reads them directly, with no read command and no load strobe. The queue starts empty and fills one window per push. Once it has seen as many pushes as it has positions, it stays full for good, and a full flag reports this.

Top module: `win_shift_queue`

## Requirements
- R1: During and right after a synchronous reset, every tap field on `taps_out` is zero and `full` is low, whether or not `push` is high during reset.
- R2: On a clock edge with `push` high, the window on `win_in` is stored at position 1, the head. It appears on any tap placed at position 1 after that edge.
- R3: On a clock edge with `push` high, the window at position k (1 ≤ k < DEPTH) moves to position k+1, for every k in the same edge.
- R4: On a clock edge with `push` low, no stored window changes, whatever value `win_in` carries.
- R5: Tap t drives bits [t·WIN_W +: WIN_W] of `taps_out`, so tap 0 sits in the least significant bits. Tap t shows the window at the position given by field t of TAP_POS (16 bits per field, field 0 lowest). Taps change only after a clock edge, with no read strobe.
- R6: `full` stays low until DEPTH pushes have been taken since reset. It goes high after the edge of the DEPTH-th push.
- R7: Once high, `full` stays high until reset. Each further push drops the window at position DEPTH and keeps all the others shifted by one.
- R8: A window keeps its word order. Word 0 occupies the least significant WORD_W bits of its field on both `win_in` and `taps_out`.
- R9: A reset that comes after the queue has filled empties it again: taps return to zero, `full` falls, and the fill count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Shift the queue and store `win_in` at the head |
| win_in | input | WIN_WORDS·WORD_W | Incoming window, flat, word 0 in the low bits |
| taps_out | output | NUM_TAPS·WIN_WORDS·WORD_W | Windows at the chosen positions, tap 0 in the low bits |
| full | output | 1 | High once DEPTH pushes have been taken since reset |

## Verification
The bench goes after the fill boundary. A fill count that is off by one would raise `full` one push early or late. A counter that does not saturate would let `full` drop again after it wraps. It checks that idle cycles with a changing `win_in` leave every tap unchanged, which catches an enable that is ignored or a head register that loads all the time. Windows with distinct words, and taps at the head, in the interior and at the tail, expose tap fields that are swapped, positions that are off by one, or words that are reordered. A reset issued after the queue is full, with `push` held high, catches a clear that misses the counter or lets the push win.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  // width of one position field inside the tap position list
  localparam int unsigned POS_FIELD_W = 16;

  // saturating fill step: grows by one per push until the limit
  function automatic int unsigned fill_step(input int unsigned cur,
                                            input logic inc,
                                            input int unsigned lim);
    if (inc && (cur < lim)) return cur + 1;
    return cur;
  endfunction

  // offset of a 1-based queue position inside the flat stage vector
  function automatic int unsigned stage_offset(input int unsigned pos,
                                               input int unsigned win_w);
    return (pos - 1) * win_w;
  endfunction

  // read one position field from a packed position list
  function automatic int unsigned pos_field(input logic [1023:0] list,
                                            input int unsigned idx);
    return int'(list[idx*POS_FIELD_W +: POS_FIELD_W]);
  endfunction

endpackage

// File: rtl/wsq_stage.sv
module wsq_stage #(
  parameter int unsigned WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [WIN_W-1:0] d_in,
  output logic [WIN_W-1:0] q_out
);

  logic [WIN_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)           hold_q <= '0;
    else if (shift_en) hold_q <= d_in;
  end

  assign q_out = hold_q;

endmodule

// File: rtl/wsq_fill.sv
module wsq_fill
  import wsq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  output logic [CNT_W-1:0] fill_cnt,
  output logic             full
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = CNT_W'(fill_step(int'(cnt_q), push, DEPTH));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign fill_cnt = cnt_q;
  assign full     = (cnt_q == LIMIT);

  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT); // R6

  AST_FILL_COUNTS_PUSH: assert property (@(posedge clk) disable iff (rst)
    (push && (cnt_q != LIMIT)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6

  AST_FILL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/wsq_taps.sv
module wsq_taps
  import wsq_pkg::*;
#(
  parameter int unsigned WIN_W    = 24,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned NUM_TAPS = 4,
  parameter logic [NUM_TAPS*POS_FIELD_W-1:0] TAP_POS = '0
) (
  input  logic [DEPTH*WIN_W-1:0]    stages_flat,
  output logic [NUM_TAPS*WIN_W-1:0] taps_flat
);

  localparam logic [1023:0] POS_LIST = 1024'(TAP_POS);

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int unsigned POS = pos_field(POS_LIST, t);
    localparam int unsigned OFS = stage_offset(POS, WIN_W);
    assign taps_flat[t*WIN_W +: WIN_W] = stages_flat[OFS +: WIN_W];
  end

endmodule

// File: rtl/win_shift_queue.sv
module win_shift_queue
  import wsq_pkg::*;
#(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned WIN_WORDS = 3,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned NUM_TAPS  = 4,
  parameter logic [NUM_TAPS*POS_FIELD_W-1:0] TAP_POS =
    {16'd8, 16'd5, 16'd2, 16'd1},
  localparam int unsigned WIN_W  = WORD_W * WIN_WORDS,
  localparam int unsigned TAPS_W = NUM_TAPS * WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [WIN_W-1:0]  win_in,
  output logic [TAPS_W-1:0] taps_out,
  output logic              full
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // flat view of all stages, position 1 (head) at offset 0
  logic [DEPTH*WIN_W-1:0] stages_flat;
  // value offered to each stage on a push
  logic [DEPTH*WIN_W-1:0] feed_flat;
  // named events for the checks below
  logic                   shift_evt;
  logic [WIN_W-1:0]       head_win;
  logic [WIN_W-1:0]       tail_win;
  logic [CNT_W-1:0]       fill_cnt;

  assign shift_evt = push;

  // unpack the incoming window word by word into the head feed
  for (genvar w = 0; w < WIN_WORDS; w++) begin : g_unpack
    assign feed_flat[w*WORD_W +: WORD_W] = win_in[w*WORD_W +: WORD_W];
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k > 0) begin : g_link
      assign feed_flat[k*WIN_W +: WIN_W] = stages_flat[(k-1)*WIN_W +: WIN_W];
    end
    wsq_stage #(.WIN_W(WIN_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_evt),
      .d_in     (feed_flat[k*WIN_W +: WIN_W]),
      .q_out    (stages_flat[k*WIN_W +: WIN_W])
    );
  end

  assign head_win = stages_flat[0 +: WIN_W];
  assign tail_win = stages_flat[(DEPTH-1)*WIN_W +: WIN_W];

  wsq_fill #(.DEPTH(DEPTH)) u_fill (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .fill_cnt (fill_cnt),
    .full     (full)
  );

  wsq_taps #(
    .WIN_W    (WIN_W),
    .DEPTH    (DEPTH),
    .NUM_TAPS (NUM_TAPS),
    .TAP_POS  (TAP_POS)
  ) u_taps (
    .stages_flat (stages_flat),
    .taps_flat   (taps_out)
  );

  AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    push |=> (head_win == $past(win_in))); // R2

  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(head_win)); // R4

  AST_HOLD_TAIL: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(tail_win)); // R4

  for (genvar k = 1; k < DEPTH; k++) begin : g_chk
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
      push |=> (stages_flat[k*WIN_W +: WIN_W] ==
                $past(stages_flat[(k-1)*WIN_W +: WIN_W]))); // R3
  end

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    full |=> full); // R7

  AST_FULL_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(push)); // R6

  AST_EMPTY_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt < CNT_W'(DEPTH)) |-> (tail_win == '0)); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!full && head_win == '0 && tail_win == '0)); // R1

endmodule

// File: tb/tb_win_shift_queue.sv
module tb_win_shift_queue;

  localparam int WORD_W    = 8;
  localparam int WIN_WORDS = 3;
  localparam int DEPTH     = 8;
  localparam int NUM_TAPS  = 4;
  localparam int WIN_W     = WORD_W * WIN_WORDS;
  localparam int TAPS_W    = NUM_TAPS * WIN_W;
  localparam int TP [NUM_TAPS] = '{1, 2, 5, 8};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              push = 1'b0;
  logic [WIN_W-1:0]  win_in = '0;
  logic [TAPS_W-1:0] taps_out;
  logic              full;

  int checks = 0;
  int fails  = 0;
  logic [WIN_W-1:0] mdl [$];
  int seed_ctr = 1;

  always #5 clk = ~clk;

  win_shift_queue #(
    .WORD_W    (WORD_W),
    .WIN_WORDS (WIN_WORDS),
    .DEPTH     (DEPTH),
    .NUM_TAPS  (NUM_TAPS),
    .TAP_POS   ({16'd8, 16'd5, 16'd2, 16'd1})
  ) dut (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .win_in   (win_in),
    .taps_out (taps_out),
    .full     (full)
  );

  task automatic check(input string tag, input string what,
                       input logic [WIN_W-1:0] act, input logic [WIN_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [WIN_W-1:0] next_win();
    logic [WIN_W-1:0] w;
    for (int i = 0; i < WIN_WORDS; i++)
      w[i*WORD_W +: WORD_W] = WORD_W'(seed_ctr * 37 + i * 11 + 5);
    seed_ctr++;
    return w;
  endfunction

  function automatic logic [WIN_W-1:0] model_at(input int pos);
    if (pos - 1 < mdl.size()) return mdl[pos-1];
    return '0;
  endfunction

  task automatic compare_all(input string tap_tag, input string full_tag);
    for (int t = 0; t < NUM_TAPS; t++)
      check(tap_tag, $sformatf("tap%0d", t),
            taps_out[t*WIN_W +: WIN_W], model_at(TP[t]));
    check(full_tag, "full", WIN_W'(full), WIN_W'(mdl.size() == DEPTH));
  endtask

  // inputs applied at a falling edge, model updated at the rising edge,
  // outputs sampled at the following falling edge
  task automatic step(input logic p, input logic [WIN_W-1:0] w,
                      input string tap_tag, input string full_tag);
    push   = p;
    win_in = w;
    @(posedge clk);
    if (p) begin
      mdl.push_front(w);
      if (mdl.size() > DEPTH) void'(mdl.pop_back());
    end
    @(negedge clk);
    compare_all(tap_tag, full_tag);
  endtask

  task automatic do_reset(input logic p, input string tag);
    rst    = 1'b1;
    push   = p;
    win_in = next_win();
    @(posedge clk);
    @(negedge clk);
    mdl.delete();
    compare_all(tag, tag);
    rst  = 1'b0;
    push = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [WIN_W-1:0] w;
    logic [WIN_W-1:0] prev;
    @(negedge clk);
    // R1: reset state, with push high during reset
    do_reset(1'b1, "R1");
    do_reset(1'b0, "R1");

    // R2: first window lands at the head
    w = next_win();
    step(1'b1, w, "R2", "R6");
    check("R2", "head tap", taps_out[0 +: WIN_W], w);

    // R4: idle cycles with a changing input leave everything in place
    for (int i = 0; i < 3; i++) step(1'b0, next_win(), "R4", "R4");

    // R3/R6: fill up to one short of full
    for (int i = 0; i < DEPTH - 2; i++) step(1'b1, next_win(), "R3", "R6");
    check("R6", "full before last push", WIN_W'(full), '0);
    step(1'b1, next_win(), "R3", "R6");
    check("R6", "full after DEPTH pushes", WIN_W'(full), WIN_W'(1));

    // R7: pushes beyond full drop the tail, interleaved with idles
    for (int i = 0; i < 20; i++) begin
      prev = model_at(DEPTH - 1);
      step(1'b1, next_win(), "R7", "R7");
      check("R7", "tail after overflow push", taps_out[3*WIN_W +: WIN_W], prev);
      if (i % 4 == 0) step(1'b0, next_win(), "R4", "R7");
    end

    // R8: distinct words keep their order
    w = {8'h33, 8'h22, 8'h11};
    step(1'b1, w, "R8", "R7");
    check("R8", "word0 low bits", WIN_W'(taps_out[0 +: WORD_W]), WIN_W'(8'h11));
    check("R8", "word2 high bits", WIN_W'(taps_out[2*WORD_W +: WORD_W]), WIN_W'(8'h33));

    // R5: tap 1 (position 2) takes the previous head after one more push
    step(1'b1, next_win(), "R5", "R7");
    check("R5", "tap1 field", taps_out[WIN_W +: WIN_W], w);
    for (int i = 0; i < 3; i++) step(1'b1, next_win(), "R5", "R7");
    check("R5", "tap2 field position 5", taps_out[2*WIN_W +: WIN_W], w);

    // R9: reset when full, with push held high
    do_reset(1'b1, "R9");
    for (int i = 0; i < DEPTH - 1; i++) step(1'b1, next_win(), "R9", "R9");
    check("R9", "not full after DEPTH-1 refills", WIN_W'(full), '0);
    step(1'b1, next_win(), "R9", "R9");
    check("R9", "full after refill", WIN_W'(full), WIN_W'(1));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule